// File: doc/BRIEF.md
# Self-Test Progress and Transmit Fault Indicator

This block drives one transmit status line from two sources. While the built-in self-test runs, it follows the character position inside the test pattern and raises the line once for each complete pass. The length of a pass and the width of the completion pulse depend on the receive clock-select setting and on the transmit mode. Separately, it holds a sticky fault for the transmit phase-align buffer. The fault is set by an over/underflow event while the buffer is in use. It is cleared when a full word-sync sequence has gone out, or when the transmit reset is sampled low.

The status output is the OR of the self-test pulse and the held fault. The pattern generator, the phase-align buffer and the decoding of "buffer in use" sit outside this block. Their results reach it as plain inputs, sampled on the character clock.

The self-test tracker is a three-state machine. **IDLE** holds the position counter at zero while self-test is off. **COUNT** advances one position per character. **PULSE** drives the completion pulse while the next pass keeps counting. The transitions are:
- IDLE→COUNT when self-test is enabled.
- COUNT→PULSE when the last position of a pass is reached.
- PULSE→PULSE while pulse cycles remain.
- PULSE→COUNT when the pulse is spent.
- Any state→IDLE when self-test is disabled.

The fault keeper is a two-state machine. **CLEAR** goes to **HELD** on an accepted fault event. **HELD** goes back to **CLEAR** on a word-sync completion or a transmit reset.

Top module: `txstat_indicator`

## Requirements
- R1: After the global reset `rst_n` is released, with no stimulus applied, `tx_status` is low.
- R2: With self-test enabled, the first clock edge with `bist_en` high counts character 0. With no word sync in the pass, a pass has 511 characters, and the pulse starts in the cycle after the edge that counts character 510 of each pass.
- R3: With `rxck_sel` = 2'b00 (LOW) and `tx_mode` ≠ 2'b00, a word sync of 16 characters is part of each pass, so a pass lasts 527 characters.
- R4: With `rxck_sel` = 2'b01 (MID), the completion pulse lasts exactly one character period, for every `tx_mode`.
- R5: With `rxck_sel` = 2'b00 (LOW), 2'b10 (HIGH) or 2'b11 (treated as HIGH), and `tx_mode` ≠ 2'b00, the completion pulse lasts 17 character periods. With 2'b10 or 2'b11, a pass stays 511 characters long.
- R6: With `rxck_sel` LOW or HIGH and `tx_mode` = 2'b00, no word sync is counted. The pass is 511 characters and the pulse lasts one character period.
- R7: Dropping `bist_en` forces the self-test contribution low at the next edge, including in the middle of a pulse. It resets the position, so the next enable starts again from character 0.
- R8: A fault event (`pab_fault_evt` high) while `pab_enabled` is high sets the held fault at the next edge.
- R9: A fault event while `pab_enabled` is low has no effect on `tx_status`.
- R10: The held fault stays high until `wsync_done` is sampled high, and it drops at that edge. A fault event in the same cycle as `wsync_done` leaves the fault clear.
- R11: Sampling `tx_rst_n` low clears the held fault. A clear has priority over a fault event in the same cycle.
- R12: `tx_status` is high whenever either the held fault or the self-test pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit character clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| bist_en | input | 1 | Self-test enable |
| rxck_sel | input | 2 | Receive clock select: 00 LOW, 01 MID, 10/11 HIGH |
| tx_mode | input | 2 | Transmit mode; 00 suppresses word sync in self-test |
| pab_enabled | input | 1 | Phase-align buffer in use (decoded outside) |
| pab_fault_evt | input | 1 | Buffer over/underflow event |
| wsync_done | input | 1 | A complete word-sync sequence has been sent |
| tx_rst_n | input | 1 | Synchronous active-low transmit reset (buffer recenter) |
| tx_status | output | 1 | Status: self-test pulse OR held buffer fault |

## Verification
The bench sweeps all sixteen combinations of clock select and mode across two full passes, and compares every cycle against a pulse position and width worked out arithmetically. Three kinds of error show up in this sweep: a design that added the sync length for the HIGH setting, one that missed the mode-00 exception, or one that was off by one at the wrap. Each would show its pulse one or sixteen cycles early or late, or with the wrong width. The bench aborts self-test both mid-pass and mid-pulse. This exposes a counter that keeps its old position, or a pulse that outlives the enable. The fault side tests a set while the buffer is off, and also a set arriving together with each kind of clear. A design with the wrong priority would leave the line stuck high.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

    typedef enum logic [1:0] {
        SEL_LOW  = 2'b00,
        SEL_MID  = 2'b01,
        SEL_HIGH = 2'b10
    } ck_sel_e;

    typedef enum logic [1:0] {
        BT_IDLE  = 2'b00,
        BT_COUNT = 2'b01,
        BT_PULSE = 2'b10
    } bist_state_e;

    typedef enum logic {
        FL_CLEAR = 1'b0,
        FL_HELD  = 1'b1
    } fault_state_e;

endpackage

// File: rtl/txstat_cfg_decode.sv
module txstat_cfg_decode
    import txstat_pkg::*;
#(
    parameter int PASS_LEN   = 511,
    parameter int SYNC_LEN   = 16,
    parameter int LONG_PULSE = 17,
    parameter int CW         = 10,
    parameter int PW         = 5
) (
    input  logic [1:0]    rxck_sel,
    input  logic [1:0]    tx_mode,
    output logic [CW-1:0] last_pos,
    output logic [PW-1:0] pulse_last
);

    logic sync_in_pass;
    logic long_pulse;

    always_comb begin
        sync_in_pass = (rxck_sel == SEL_LOW) && (tx_mode != 2'b00);
        long_pulse   = (rxck_sel != SEL_MID) && (tx_mode != 2'b00);
        last_pos     = sync_in_pass ? CW'(PASS_LEN + SYNC_LEN - 1) : CW'(PASS_LEN - 1);
        pulse_last   = long_pulse ? PW'(LONG_PULSE - 1) : '0;
    end

endmodule

// File: rtl/txstat_bist_tracker.sv
module txstat_bist_tracker
    import txstat_pkg::*;
#(
    parameter int CW = 10,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bist_en,
    input  logic [1:0]    rxck_sel,
    input  logic [1:0]    tx_mode,
    input  logic [CW-1:0] last_pos,
    input  logic [PW-1:0] pulse_last,
    output logic          pulse_o
);

    bist_state_e   state_q, state_d;
    logic [CW-1:0] pos_q;
    logic [PW-1:0] left_q;
    logic          wrap;

    assign wrap = bist_en && (pos_q >= last_pos);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BT_IDLE: begin
                if (wrap)         state_d = BT_PULSE;
                else if (bist_en) state_d = BT_COUNT;
            end
            BT_COUNT: begin
                if (!bist_en)     state_d = BT_IDLE;
                else if (wrap)    state_d = BT_PULSE;
            end
            BT_PULSE: begin
                if (!bist_en)           state_d = BT_IDLE;
                else if (wrap)          state_d = BT_PULSE;
                else if (left_q == '0)  state_d = BT_COUNT;
            end
            default: state_d = BT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BT_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= '0;
            left_q <= '0;
        end else if (!bist_en) begin
            pos_q  <= '0;
            left_q <= '0;
        end else begin
            pos_q <= wrap ? '0 : pos_q + 1'b1;
            if (wrap)
                left_q <= pulse_last;
            else if (state_q == BT_PULSE && left_q != '0)
                left_q <= left_q - 1'b1;
        end
    end

    always_comb begin
        pulse_o = (state_q == BT_PULSE);
    end

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bist_en |=> !pulse_o);

    assert_mid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pulse_o) && rxck_sel == SEL_MID && bist_en) |=> !pulse_o);

    assert_short_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pulse_o) && tx_mode == 2'b00 && bist_en) |=> !pulse_o);

    assert_pulse_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(bist_en));

endmodule

// File: rtl/txstat_fault_keeper.sv
module txstat_fault_keeper
    import txstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pab_enabled,
    input  logic pab_fault_evt,
    input  logic wsync_done,
    input  logic tx_rst_n,
    output logic fault_o
);

    fault_state_e state_q, state_d;
    logic clear_req;
    logic set_req;

    assign clear_req = !tx_rst_n || wsync_done;
    assign set_req   = pab_enabled && pab_fault_evt;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: if (set_req && !clear_req) state_d = FL_HELD;
            FL_HELD:  if (clear_req)             state_d = FL_CLEAR;
            default:  state_d = FL_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        fault_o = (state_q == FL_HELD);
    end

    assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pab_enabled && pab_fault_evt && tx_rst_n && !wsync_done) |=> fault_o);

    assert_ignore_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pab_enabled && !fault_o) |=> !fault_o);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !wsync_done && tx_rst_n) |=> fault_o);

    assert_recenter_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_rst_n |=> !fault_o);

endmodule

// File: rtl/txstat_indicator.sv
module txstat_indicator
    import txstat_pkg::*;
#(
    parameter int PASS_LEN   = 511,
    parameter int SYNC_LEN   = 16,
    parameter int LONG_PULSE = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bist_en,
    input  logic [1:0] rxck_sel,
    input  logic [1:0] tx_mode,
    input  logic       pab_enabled,
    input  logic       pab_fault_evt,
    input  logic       wsync_done,
    input  logic       tx_rst_n,
    output logic       tx_status
);

    localparam int CW = $clog2(PASS_LEN + SYNC_LEN + 1);
    localparam int PW = $clog2(LONG_PULSE + 1);

    logic [CW-1:0] last_pos;
    logic [PW-1:0] pulse_last;
    logic          bist_pulse;
    logic          fault_held;

    txstat_cfg_decode #(
        .PASS_LEN  (PASS_LEN),
        .SYNC_LEN  (SYNC_LEN),
        .LONG_PULSE(LONG_PULSE),
        .CW        (CW),
        .PW        (PW)
    ) cfg_i (
        .rxck_sel  (rxck_sel),
        .tx_mode   (tx_mode),
        .last_pos  (last_pos),
        .pulse_last(pulse_last)
    );

    txstat_bist_tracker #(
        .CW(CW),
        .PW(PW)
    ) bist_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bist_en   (bist_en),
        .rxck_sel  (rxck_sel),
        .tx_mode   (tx_mode),
        .last_pos  (last_pos),
        .pulse_last(pulse_last),
        .pulse_o   (bist_pulse)
    );

    txstat_fault_keeper fault_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pab_enabled  (pab_enabled),
        .pab_fault_evt(pab_fault_evt),
        .wsync_done   (wsync_done),
        .tx_rst_n     (tx_rst_n),
        .fault_o      (fault_held)
    );

    assign tx_status = bist_pulse | fault_held;

    assert_fault_visible_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pab_enabled && pab_fault_evt && tx_rst_n && !wsync_done) |=> tx_status);

endmodule

// File: tb/txstat_indicator_tb_top.sv
`timescale 1ns/1ps
module txstat_indicator_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bist_en = 1'b0;
    logic [1:0] rxck_sel = 2'b01;
    logic [1:0] tx_mode = 2'b00;
    logic       pab_enabled = 1'b0;
    logic       pab_fault_evt = 1'b0;
    logic       wsync_done = 1'b0;
    logic       tx_rst_n = 1'b1;
    logic       tx_status;

    int n_total = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    txstat_indicator dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bist_en      (bist_en),
        .rxck_sel     (rxck_sel),
        .tx_mode      (tx_mode),
        .pab_enabled  (pab_enabled),
        .pab_fault_evt(pab_fault_evt),
        .wsync_done   (wsync_done),
        .tx_rst_n     (tx_rst_n),
        .tx_status    (tx_status)
    );

    task automatic chk(input logic got, input logic exp, input string req);
        n_total++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: tx_status=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    function automatic int pass_len(input logic [1:0] s, input logic [1:0] m);
        return (s == 2'b00 && m != 2'b00) ? 527 : 511;
    endfunction

    function automatic int pulse_w(input logic [1:0] s, input logic [1:0] m);
        return (s == 2'b01 || m == 2'b00) ? 1 : 17;
    endfunction

    function automatic logic bist_exp(input int j, input int len, input int w);
        return ((j + 1) >= len) && (((j + 1) % len) < w);
    endfunction

    function automatic string req_of(input logic [1:0] s, input logic [1:0] m);
        if (s == 2'b01) return "R4";
        if (m == 2'b00) return "R6";
        if (s == 2'b00) return "R3/R5";
        return "R2/R5";
    endfunction

    // Enable self-test at a negedge and check n samples, each after an edge
    task automatic run_bist(input int n, input string req);
        int len;
        int w;
        len = pass_len(rxck_sel, tx_mode);
        w   = pulse_w(rxck_sel, tx_mode);
        bist_en = 1'b1;
        for (int j = 0; j < n; j++) begin
            @(posedge clk);
            @(negedge clk);
            chk(tx_status, bist_exp(j, len, w), req);
        end
    endtask

    task automatic stop_bist(input string req);
        bist_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(tx_status, 1'b0, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tx_status, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_status, 1'b0, "R1");
        repeat (4) @(negedge clk);
        chk(tx_status, 1'b0, "R1");

        // Sweep all clock-select and mode settings over two passes
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 4; m++) begin
                rxck_sel = 2'(s);
                tx_mode  = 2'(m);
                run_bist(2 * pass_len(2'(s), 2'(m)) + 20, req_of(2'(s), 2'(m)));
                stop_bist("R7");
            end
        end

        // Abort mid-pass, then restart from character 0 (R7)
        rxck_sel = 2'b00;
        tx_mode  = 2'b01;
        run_bist(300, "R3");
        stop_bist("R7");
        repeat (3) begin
            @(negedge clk);
            chk(tx_status, 1'b0, "R7");
        end
        run_bist(527 + 5, "R7");
        stop_bist("R7");
        @(negedge clk);
        run_bist(527 + 20, "R7");
        stop_bist("R7");

        // Fault ignored while buffer disabled (R9)
        pab_enabled = 1'b0;
        pab_fault_evt = 1'b1;
        @(negedge clk);
        pab_fault_evt = 1'b0;
        chk(tx_status, 1'b0, "R9");
        @(negedge clk);
        chk(tx_status, 1'b0, "R9");

        // Fault set and held (R8, R10)
        pab_enabled = 1'b1;
        pab_fault_evt = 1'b1;
        @(negedge clk);
        pab_fault_evt = 1'b0;
        chk(tx_status, 1'b1, "R8");
        pab_enabled = 1'b0;
        repeat (20) begin
            @(negedge clk);
            chk(tx_status, 1'b1, "R10");
        end
        wsync_done = 1'b1;
        @(negedge clk);
        wsync_done = 1'b0;
        chk(tx_status, 1'b0, "R10");

        // Event together with word-sync completion leaves it clear (R10)
        pab_enabled = 1'b1;
        pab_fault_evt = 1'b1;
        wsync_done = 1'b1;
        @(negedge clk);
        pab_fault_evt = 1'b0;
        wsync_done = 1'b0;
        chk(tx_status, 1'b0, "R10");

        // Transmit reset clears; wins over simultaneous event (R11)
        pab_fault_evt = 1'b1;
        @(negedge clk);
        pab_fault_evt = 1'b0;
        chk(tx_status, 1'b1, "R8");
        tx_rst_n = 1'b0;
        @(negedge clk);
        chk(tx_status, 1'b0, "R11");
        pab_fault_evt = 1'b1;
        @(negedge clk);
        pab_fault_evt = 1'b0;
        tx_rst_n = 1'b1;
        chk(tx_status, 1'b0, "R11");
        @(negedge clk);
        chk(tx_status, 1'b0, "R11");

        // Held fault dominates the self-test pattern (R12)
        pab_fault_evt = 1'b1;
        @(negedge clk);
        pab_fault_evt = 1'b0;
        rxck_sel = 2'b01;
        tx_mode  = 2'b10;
        bist_en  = 1'b1;
        for (int j = 0; j < 600; j++) begin
            @(posedge clk);
            @(negedge clk);
            chk(tx_status, 1'b1, "R12");
        end
        bist_en = 1'b0;
        tx_rst_n = 1'b0;
        @(negedge clk);
        tx_rst_n = 1'b1;
        chk(tx_status, 1'b0, "R12");
        run_bist(511 + 3, "R12");
        stop_bist("R7");

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule